// File: doc/BRIEF.md
# Edge-Stamping Capture Timer

This block timestamps transitions on one external digital input. A free-running 16-bit counter advances on every system clock. The input first passes through a two-flop synchronizer and then through a stability filter. The filter accepts a new level only after four consecutive equal samples. Each accepted transition copies the counter into a register of its own: one register for rising transitions and one for falling transitions. Software can then take the period as the difference of two successive rising stamps, and the high time as the falling stamp minus the rising stamp.

The stamp is corrected for the pipeline delay. The stored value is the count at the first clock edge that saw the new input level. Each edge kind has its own pending flag and its own overrun flag. The interrupt request is active while either pending flag is set. The host clears a kind by pulsing its acknowledge bit.

Top module: `ect_capture_top`

## Requirements
- R1: While reset is high and after it, before any accepted transition, both stamps read 0 and all flags and the interrupt read 0.
- R2: The counter starts at 0 and increments on every clock edge with reset low. A stamp equals the number of such edges, modulo 65536, up to and including the first edge that sampled the new input level.
- R3: A rising transition that is held for at least 4 clocks writes `rise_stamp` and sets `cap_flag[0]` (bit 0 is the rising kind). This happens exactly 4 clock edges after the synchronizer output changes, which is 6 edges after the first sampling edge.
- R4: A falling transition that is held for at least 4 clocks writes `fall_stamp` and sets `cap_flag[1]` (bit 1 is the falling kind), with the same timing as R3.
- R5: A high or low excursion that lasts fewer than 4 clocks is discarded. Neither stamp changes, no flag is set, and the filtered level is unchanged.
- R6: `irq` is 1 exactly when at least one bit of `cap_flag` is 1.
- R7: Pulsing `ack[i]` for one clock clears `cap_flag[i]` and `ovr_flag[i]` at that edge and leaves the other kind untouched.
- R8: If a transition of a kind is accepted while that kind's flag is still set and not being acknowledged, `ovr_flag` for that kind is set and the stamp is overwritten with the new value.
- R9: The counter wraps from 0xFFFF to 0 without stopping, so a modulo-65536 difference of stamps that straddle the wrap gives the true interval.
- R10: An input with 4 clocks high and 4 clocks low (an 8-clock period) has every transition accepted, with correct stamps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cap_in | input | 1 | Asynchronous capture input |
| ack | input | 2 | Host acknowledge, bit 0 rising kind, bit 1 falling kind |
| rise_stamp | output | 16 | Count latched at the last accepted rising transition |
| fall_stamp | output | 16 | Count latched at the last accepted falling transition |
| cap_flag | output | 2 | Pending capture flags, bit 0 rising, bit 1 falling |
| ovr_flag | output | 2 | Overrun flags, same bit order |
| irq | output | 1 | Interrupt request |

## Verification
The bench drives pulses of 3 and 4 clocks at the filter boundary. A filter that counted one sample too many would lose the 4-clock pulses, and one that counted one too few would pass the 3-clock glitches. Every stamp is compared with a count the bench keeps for itself, and the flag must rise on the exact expected edge. An error in the delay correction therefore shows up as a value off by a constant, and an extra pipeline stage shows up as a flag one cycle late. Back-to-back 8-clock periods exercise overrun while a flag is still pending. A run across the counter wrap checks that a design which saturated or stopped at 0xFFFF would give a wrong period.

// File: rtl/ect_pkg.sv
package ect_pkg;

    localparam int CNT_W_DEF  = 16;
    localparam int SYNC_DEF   = 2;
    localparam int FILT_DEF   = 4;
    localparam int NUM_EDGES  = 2;
    localparam int EDGE_RISE  = 0;
    localparam int EDGE_FALL  = 1;

    // accepted transition strobes, bit order matches EDGE_RISE/EDGE_FALL
    typedef struct packed {
        logic fall;
        logic rise;
    } edge_evt_t;

    // clock edges between first sampling of the new level and the stamp write,
    // minus the one edge the counter itself adds
    function automatic int stamp_lag(input int sync_stages, input int filt_len);
        return sync_stages + filt_len - 2;
    endfunction

endpackage

// File: rtl/ect_free_counter.sv
module ect_free_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] cnt_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;

    // R9
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '1) |=> (cnt_q == '0));

endmodule

// File: rtl/ect_level_filter.sv
module ect_level_filter
    import ect_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      raw_i,
    output edge_evt_t evt_o
);

    localparam int RUN_W = $clog2(FILT_LEN + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   samp;
    logic                   level_q;
    logic [RUN_W-1:0]       run_q;
    logic                   accept;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
    end

    assign samp   = sync_q[SYNC_STAGES-1];
    assign accept = (samp != level_q) && (run_q == RUN_W'(FILT_LEN - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= 1'b0;
            run_q   <= '0;
        end else if (samp != level_q) begin
            if (accept) begin
                level_q <= samp;
                run_q   <= '0;
            end else begin
                run_q   <= run_q + 1'b1;
            end
        end else begin
            run_q <= '0;
        end
    end

    assign evt_o.rise = accept &  samp;
    assign evt_o.fall = accept & ~samp;

    // R5
    level_needs_full_run_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(level_q) |-> ($past(run_q) == RUN_W'(FILT_LEN - 1)));

endmodule

// File: rtl/ect_edge_slot.sv
module ect_edge_slot #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit_i,
    input  logic             ack_i,
    input  logic [CNT_W-1:0] stamp_i,
    output logic [CNT_W-1:0] val_o,
    output logic             flag_o,
    output logic             ovr_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            val_o  <= '0;
            flag_o <= 1'b0;
            ovr_o  <= 1'b0;
        end else if (hit_i) begin
            val_o  <= stamp_i;
            flag_o <= 1'b1;
            if (flag_o && !ack_i) ovr_o <= 1'b1;
            else if (ack_i)       ovr_o <= 1'b0;
        end else if (ack_i) begin
            flag_o <= 1'b0;
            ovr_o  <= 1'b0;
        end
    end

    // R3
    hit_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        hit_i |=> flag_o);

    // R7
    ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_i && !hit_i) |=> (!flag_o && !ovr_o));

    // R8
    overrun_set_chk: assert property (@(posedge clk) disable iff (rst)
        (hit_i && flag_o && !ack_i) |=> ovr_o);

    // R5
    stamp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !hit_i |=> $stable(val_o));

endmodule

// File: rtl/ect_capture_top.sv
module ect_capture_top
    import ect_pkg::*;
#(
    parameter int CNT_W       = CNT_W_DEF,
    parameter int SYNC_STAGES = SYNC_DEF,
    parameter int FILT_LEN    = FILT_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_in,
    input  logic [1:0]       ack,
    output logic [CNT_W-1:0] rise_stamp,
    output logic [CNT_W-1:0] fall_stamp,
    output logic [1:0]       cap_flag,
    output logic [1:0]       ovr_flag,
    output logic             irq
);

    localparam int LAG = stamp_lag(SYNC_STAGES, FILT_LEN);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] stamp;
    edge_evt_t        evt;
    logic [1:0]       hits;
    logic [CNT_W-1:0] vals [NUM_EDGES];

    ect_free_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .cnt_o (cnt)
    );

    ect_level_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_filt (
        .clk   (clk),
        .rst   (rst),
        .raw_i (cap_in),
        .evt_o (evt)
    );

    assign stamp = cnt - CNT_W'(LAG);
    assign hits  = evt;

    for (genvar e = 0; e < NUM_EDGES; e++) begin : g_slot
        ect_edge_slot #(.CNT_W(CNT_W)) u_slot (
            .clk     (clk),
            .rst     (rst),
            .hit_i   (hits[e]),
            .ack_i   (ack[e]),
            .stamp_i (stamp),
            .val_o   (vals[e]),
            .flag_o  (cap_flag[e]),
            .ovr_o   (ovr_flag[e])
        );
    end

    assign rise_stamp = vals[EDGE_RISE];
    assign fall_stamp = vals[EDGE_FALL];
    assign irq        = |cap_flag;

    // R6
    irq_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(hits != 2'b00));

endmodule

// File: tb/sim_ect_capture_top.sv
`timescale 1ns/1ps
module sim_ect_capture_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cap_in = 1'b0;
    logic [1:0]  ack = 2'b00;
    logic [15:0] rise_stamp, fall_stamp;
    logic [1:0]  cap_flag, ovr_flag;
    logic        irq;

    ect_capture_top u0 (
        .clk(clk), .rst(rst), .cap_in(cap_in), .ack(ack),
        .rise_stamp(rise_stamp), .fall_stamp(fall_stamp),
        .cap_flag(cap_flag), .ovr_flag(ovr_flag), .irq(irq)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) if (!rst) cyc <= cyc + 1;

    typedef struct {
        int          e;
        int          due;
        logic [15:0] val;
        logic        ovr;
        logic        pre_clear;
    } item_t;

    item_t q[$];
    int checks = 0;
    int errors = 0;
    logic [1:0]  pend_m = 2'b00;
    logic [1:0]  ovr_m  = 2'b00;
    logic [15:0] last_m [2] = '{16'h0, 16'h0};
    logic        lvl_m  = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    // driver: holds a level for n clocks and predicts the resulting capture
    task automatic hold(input logic v, input int n);
        item_t it;
        int    e;
        @(negedge clk);
        cap_in = v;
        if (v != lvl_m && n >= 4) begin
            e = v ? 0 : 1;
            it.pre_clear = !pend_m[e];
            ovr_m[e]  = ovr_m[e] | pend_m[e];
            pend_m[e] = 1'b1;
            it.e   = e;
            it.due = cyc + 6;
            it.val = 16'(cyc + 1);
            it.ovr = ovr_m[e];
            last_m[e] = it.val;
            q.push_back(it);
            lvl_m = v;
        end
        repeat (n - 1) @(negedge clk);
    endtask

    task automatic do_ack(input logic [1:0] m);
        @(negedge clk);
        ack = m;
        @(negedge clk);
        ack = 2'b00;
        pend_m = pend_m & ~m;
        ovr_m  = ovr_m & ~m;
        chk(cap_flag == pend_m, "R7", "cap_flag after ack", cap_flag, pend_m);
        chk(ovr_flag == ovr_m,  "R7", "ovr_flag after ack", ovr_flag, ovr_m);
        chk(irq == (pend_m != 2'b00), "R6", "irq after ack", irq, pend_m != 2'b00);
    endtask

    // monitor: pops expected captures at their due cycle
    item_t mi;
    always @(negedge clk) begin
        if (!rst && q.size() > 0) begin
            if (q[0].due - 1 == cyc && q[0].pre_clear)
                chk(cap_flag[q[0].e] == 1'b0, q[0].e == 0 ? "R3" : "R4",
                    "flag early", cap_flag[q[0].e], 0);
            if (q[0].due == cyc) begin
                mi = q.pop_front();
                if (mi.e == 0) begin
                    chk(cap_flag[0] == 1'b1, "R3", "rise flag", cap_flag[0], 1);
                    chk(rise_stamp == mi.val, "R3", "rise_stamp", rise_stamp, mi.val);
                end else begin
                    chk(cap_flag[1] == 1'b1, "R4", "fall flag", cap_flag[1], 1);
                    chk(fall_stamp == mi.val, "R4", "fall_stamp", fall_stamp, mi.val);
                end
                chk(ovr_flag[mi.e] == mi.ovr, "R8", "ovr_flag", ovr_flag[mi.e], mi.ovr);
                chk(irq == 1'b1, "R6", "irq with pending", irq, 1);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    logic [15:0] r1, r2;

    initial begin
        repeat (3) @(negedge clk);
        chk(rise_stamp == 16'h0, "R1", "rise_stamp reset", rise_stamp, 0);
        chk(fall_stamp == 16'h0, "R1", "fall_stamp reset", fall_stamp, 0);
        chk(cap_flag == 2'b00, "R1", "cap_flag reset", cap_flag, 0);
        chk(ovr_flag == 2'b00, "R1", "ovr_flag reset", ovr_flag, 0);
        chk(irq == 1'b0, "R1", "irq reset", irq, 0);
        rst = 1'b0;

        // basic rise and fall
        hold(1'b0, 5);
        hold(1'b1, 6);
        hold(1'b0, 10);
        chk(rise_stamp == last_m[0], "R2", "stamp equals clocks since reset", rise_stamp, last_m[0]);
        chk(cap_flag == 2'b11, "R6", "both pending", cap_flag, 3);
        chk(irq == 1'b1, "R6", "irq with both pending", irq, 1);
        do_ack(2'b01);
        do_ack(2'b10);

        // glitch rejection
        hold(1'b1, 3);
        hold(1'b0, 10);
        chk(cap_flag == 2'b00, "R5", "short high ignored", cap_flag, 0);
        chk(rise_stamp == last_m[0], "R5", "rise_stamp kept", rise_stamp, last_m[0]);
        hold(1'b1, 8);
        hold(1'b0, 2);
        hold(1'b1, 8);
        chk(cap_flag == 2'b01, "R5", "short low ignored", cap_flag, 1);
        chk(fall_stamp == last_m[1], "R5", "fall_stamp kept", fall_stamp, last_m[1]);
        do_ack(2'b01);
        hold(1'b0, 8);
        do_ack(2'b10);

        // minimum period, overrun
        for (int k = 0; k < 3; k++) begin
            hold(1'b1, 4);
            hold(1'b0, 4);
        end
        hold(1'b0, 8);
        chk(16'(fall_stamp - rise_stamp) == 16'd4, "R10", "high time at 8-clock period",
            16'(fall_stamp - rise_stamp), 4);
        chk(ovr_flag == 2'b11, "R8", "overrun both kinds", ovr_flag, 3);
        do_ack(2'b11);

        // counter wrap
        while (cyc < 65528) @(negedge clk);
        hold(1'b1, 8);
        r1 = last_m[0];
        hold(1'b0, 8);
        hold(1'b1, 8);
        r2 = last_m[0];
        hold(1'b0, 8);
        chk(rise_stamp == r2, "R9", "stamp after wrap", rise_stamp, r2);
        chk(rise_stamp < r1, "R9", "stamp wrapped below earlier one", rise_stamp, r1);
        chk(16'(rise_stamp - r1) == 16'd16, "R9", "period across wrap",
            16'(rise_stamp - r1), 16);
        do_ack(2'b11);

        repeat (10) @(negedge clk);
        chk(q.size() == 0, "R3", "all predicted captures seen", q.size(), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule